// File: doc/BRIEF.md
# Power mode and peripheral clock controller

This block decides which clocks of a small processor system may toggle. It is fed by the fast processor clock and drives five outputs. The first is a core clock enable. The second is a peripheral clock enable pulse at a programmable fraction of the processor clock. The third is one clock enable per peripheral. The last two are the oscillator enable and the PLL enable. Clock gating itself happens downstream, and each enable marks the processor-clock cycles in which the gated clock would tick.

Software uses one write port with three addresses: mode command, divider code and peripheral mask. The controller has four states. RUN is normal operation. IDLE stops only the core, while the peripherals keep clocking and can raise interrupts. PDOWN stops every clock and turns the oscillator and PLL off. WARM waits for the oscillator to settle after a wake.

The transitions are:
- RUN to IDLE on a mode write with bit 1 = 0 and bit 0 = 1.
- RUN to PDOWN on a mode write with bit 1 = 1.
- IDLE to RUN on any interrupt input.
- PDOWN to WARM on an asynchronously captured wake input.
- WARM to RUN after a fixed count of settling cycles.

Reset returns the block to RUN from any state.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the state is RUN: core_clk_en, osc_en and pll_en are 1, the divider ratio is 1/1 (pclk_en high in every cycle), and every bit of the peripheral mask is 1.
- R2: A write in RUN to address 0 with data bit 1 = 0 and bit 0 = 1 enters IDLE from the next cycle. In IDLE, core_clk_en is 0, osc_en and pll_en stay 1, and pclk_en and periph_en keep their cadence.
- R3: In IDLE, any bit of irq high at a rising edge returns the block to RUN from the next cycle. In RUN, irq has no effect.
- R4: A write in RUN to address 0 with data bit 1 = 1 (bit 0 ignored) enters PDOWN from the next cycle. In PDOWN, every clock enable, osc_en and pll_en are 0, and irq has no effect.
- R5: In PDOWN, a high level on any wake_async bit is captured without a clock edge, even when it is shorter than a cycle and falls between edges. The block is in WARM after the third rising edge that follows it. Wake pulses in RUN or IDLE have no effect.
- R6: WARM lasts STABLE_CYC cycles, with osc_en and pll_en at 1 and core_clk_en, pclk_en and periph_en at 0. RUN follows.
- R7: Address 1, data bits [1:0], selects the peripheral ratio: code 00 gives 1/4, 01 gives 1/1 and 10 gives 1/2. Code 11 leaves the ratio unchanged. At ratio 1/N, pclk_en is high for one cycle in every N.
- R8: A new ratio takes effect only after the current divider period ends with its pclk_en pulse, so no period is ever cut short.
- R9: Address 2, data bits [N_PERIPH-1:0], is the peripheral mask, and periph_en[i] equals pclk_en AND mask bit i.
- R10: Writes are accepted only in RUN. The mask and the ratio are kept across IDLE and PDOWN.
- R11: The divider phase is frozen in PDOWN and WARM and resumes from the same point in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 divider, 2 mask |
| wr_data | input | DATA_W | Write data |
| irq | input | N_IRQ | Enabled interrupt requests (wake IDLE) |
| wake_async | input | N_WAKE | Clockless wake requests (wake PDOWN) |
| core_clk_en | output | 1 | Core clock enable |
| pclk_en | output | 1 | Peripheral clock enable pulse |
| periph_en | output | N_PERIPH | Per-peripheral clock enables |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The hardest case to reach is a wake pulse that is narrower than half a clock period and falls entirely between two rising edges while the block is powered down. No synchronous sampling would see such a pulse, so only the asynchronous capture can recover it. The bench drives a sub-nanosecond pulse in the middle of a cycle in PDOWN. It then follows the three-edge latency into WARM, the settling count and the return to RUN with the divider phase and mask intact. It also sends the same kind of pulse in IDLE, where it must leave no trace.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PDOWN = 2'd2,
        ST_WARM  = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        DIV1 = 2'd0,
        DIV2 = 2'd1,
        DIV4 = 2'd2
    } div_sel_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;

    localparam logic [1:0] CODE_QUARTER = 2'b00;
    localparam logic [1:0] CODE_FULL    = 2'b01;
    localparam logic [1:0] CODE_HALF    = 2'b10;
endpackage

// File: rtl/pwr_wake_sync.sv
`timescale 1ns/1ps
module pwr_wake_sync #(
    parameter int N_WAKE      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic [N_WAKE-1:0] wake_async,
    output logic              wake_req
);
    logic                   wake_any;
    logic                   catch_q;
    logic [SYNC_STAGES-1:0] sync_q;

    assign wake_any = |wake_async;

    // capture flop: set without a clock edge, cleared while not armed
    always_ff @(posedge clk or negedge rst_n or posedge wake_any) begin
        if (!rst_n) begin
            catch_q <= 1'b0;
        end else if (wake_any) begin
            catch_q <= 1'b1;
        end else if (!armed) begin
            catch_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else if (!armed) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], catch_q};
        end
    end

    assign wake_req = sync_q[SYNC_STAGES-1];

    // R5
    wake_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !wake_req);
endmodule

// File: rtl/pwr_pclk_div.sv
`timescale 1ns/1ps
module pwr_pclk_div
    import pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_en,
    input  div_sel_e next_sel,
    output logic     tick
);
    logic [1:0] cnt_q;
    logic [1:0] last;
    div_sel_e   cur_q;

    always_comb begin
        unique case (cur_q)
            DIV4:    last = 2'd3;
            DIV2:    last = 2'd1;
            default: last = 2'd0;
        endcase
    end

    assign tick = run_en && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
            cur_q <= DIV1;
        end else if (run_en) begin
            if (tick) begin
                cnt_q <= 2'd0;
                cur_q <= next_sel;
            end else begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick) |=> $stable(cur_q));

    // R11
    phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(cnt_q) && $stable(cur_q)));
endmodule

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int STABLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_idle,
    input  logic       req_pd,
    input  logic       irq_any,
    input  logic       wake_req,
    output pwr_state_e state,
    output logic       core_run,
    output logic       osc_on,
    output logic       pll_on,
    output logic       div_run,
    output logic       wake_arm
);
    localparam int WC_W = $clog2(STABLE_CYC + 1);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(STABLE_CYC - 1);

    pwr_state_e      state_d;
    logic [WC_W-1:0] warm_cnt;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN: begin
                if (req_pd) begin
                    state_d = ST_PDOWN;
                end else if (req_idle) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE:  if (irq_any) state_d = ST_RUN;
            ST_PDOWN: if (wake_req) state_d = ST_WARM;
            ST_WARM:  if (warm_cnt == WC_LAST) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (state == ST_WARM) begin
            warm_cnt <= warm_cnt + 1'b1;
        end else begin
            warm_cnt <= '0;
        end
    end

    always_comb begin
        core_run = 1'b0;
        osc_on   = 1'b1;
        pll_on   = 1'b1;
        div_run  = 1'b0;
        wake_arm = 1'b0;
        unique case (state)
            ST_RUN: begin
                core_run = 1'b1;
                div_run  = 1'b1;
            end
            ST_IDLE: div_run = 1'b1;
            ST_PDOWN: begin
                osc_on   = 1'b0;
                pll_on   = 1'b0;
                wake_arm = 1'b1;
            end
            default: ;
        endcase
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !irq_any) |=> (state == ST_IDLE));

    // R4
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN && !wake_req) |=> (state == ST_PDOWN));

    // R6
    warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM && warm_cnt < WC_LAST) |=> (state == ST_WARM));
endmodule

// File: rtl/pwr_clk_ctrl.sv
`timescale 1ns/1ps
module pwr_clk_ctrl
    import pwr_pkg::*;
#(
    parameter int N_PERIPH   = 8,
    parameter int N_IRQ      = 4,
    parameter int N_WAKE     = 2,
    parameter int DATA_W     = 8,
    parameter int STABLE_CYC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [N_IRQ-1:0]    irq,
    input  logic [N_WAKE-1:0]   wake_async,
    output logic                core_clk_en,
    output logic                pclk_en,
    output logic [N_PERIPH-1:0] periph_en,
    output logic                osc_en,
    output logic                pll_en
);
    pwr_state_e          state;
    logic                wr_ok;
    logic                req_idle;
    logic                req_pd;
    logic                div_run;
    logic                wake_arm;
    logic                wake_req;
    div_sel_e            div_next;
    logic [N_PERIPH-1:0] mask_q;

    assign wr_ok    = wr_en && (state == ST_RUN);
    assign req_pd   = wr_ok && (wr_addr == ADDR_MODE) && wr_data[1];
    assign req_idle = wr_ok && (wr_addr == ADDR_MODE) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_next <= DIV1;
        end else if (wr_ok && wr_addr == ADDR_DIV) begin
            case (wr_data[1:0])
                CODE_QUARTER: div_next <= DIV4;
                CODE_FULL:    div_next <= DIV1;
                CODE_HALF:    div_next <= DIV2;
                default:      div_next <= div_next;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_ok && wr_addr == ADDR_MASK) begin
            mask_q <= wr_data[N_PERIPH-1:0];
        end
    end

    pwr_fsm #(.STABLE_CYC(STABLE_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_idle (req_idle),
        .req_pd   (req_pd),
        .irq_any  (|irq),
        .wake_req (wake_req),
        .state    (state),
        .core_run (core_clk_en),
        .osc_on   (osc_en),
        .pll_on   (pll_en),
        .div_run  (div_run),
        .wake_arm (wake_arm)
    );

    pwr_wake_sync #(.N_WAKE(N_WAKE), .SYNC_STAGES(2)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (wake_arm),
        .wake_async (wake_async),
        .wake_req   (wake_req)
    );

    pwr_pclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (div_run),
        .next_sel (div_next),
        .tick     (pclk_en)
    );

    for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
        assign periph_en[i] = pclk_en & mask_q[i];
    end

    // R10
    regs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> ($stable(mask_q) && $stable(div_next)));

    // R4
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!core_clk_en && !pclk_en && periph_en == '0));
endmodule

// File: tb/test_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module test_pwr_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int NI  = 4;
    localparam int NW  = 2;
    localparam int STB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [7:0]    wr_data = 8'd0;
    logic [NI-1:0] irq = '0;
    logic [NW-1:0] wake_async = '0;
    logic          core_clk_en, pclk_en, osc_en, pll_en;
    logic [NP-1:0] periph_en;

    pwr_clk_ctrl #(.N_PERIPH(NP), .N_IRQ(NI), .N_WAKE(NW), .DATA_W(8), .STABLE_CYC(STB)) i_pwr_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .wake_async(wake_async), .core_clk_en(core_clk_en), .pclk_en(pclk_en),
        .periph_en(periph_en), .osc_en(osc_en), .pll_en(pll_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // model: 0 run, 1 idle, 2 power-down, 3 warm-up
    int            m_st = 0;
    int            m_ph = 0;
    int            m_per = 1;
    int            m_pend = 1;
    int            m_wk = 0;
    int            m_wc = 0;
    bit            m_hit = 1'b0;
    logic [NP-1:0] m_mask = '1;
    string         tag = "R1";
    int            n_cmp = 0;
    int            n_bad = 0;
    int            cyc = 0;

    function automatic bit m_running();
        return (m_st == 0) || (m_st == 1);
    endfunction

    function automatic bit m_pulse();
        return m_running() && (m_ph == m_per - 1);
    endfunction

    task automatic chk(input string nm, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, nm, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("core_clk_en", NP'(core_clk_en), NP'(m_st == 0));
            chk("osc_en", NP'(osc_en), NP'(m_st != 2));
            chk("pll_en", NP'(pll_en), NP'(m_st != 2));
            chk("pclk_en", NP'(pclk_en), NP'(m_pulse()));
            chk("periph_en", periph_en, m_pulse() ? m_mask : '0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_per = 1; m_pend = 1;
            m_wk = 0; m_wc = 0; m_hit = 1'b0; m_mask = '1;
        end else begin
            if (m_running()) begin
                if (m_pulse()) begin
                    m_ph = 0;
                    m_per = m_pend;
                end else begin
                    m_ph++;
                end
            end
            case (m_st)
                0: if (wr_en) begin
                    if (wr_addr == 2'd0) begin
                        if (wr_data[1]) m_st = 2;
                        else if (wr_data[0]) m_st = 1;
                    end else if (wr_addr == 2'd1) begin
                        if (wr_data[1:0] == 2'b00) m_pend = 4;
                        else if (wr_data[1:0] == 2'b01) m_pend = 1;
                        else if (wr_data[1:0] == 2'b10) m_pend = 2;
                    end else if (wr_addr == 2'd2) begin
                        m_mask = wr_data[NP-1:0];
                    end
                end
                1: if (|irq) m_st = 0;
                2: if (m_hit) begin
                    m_wk++;
                    if (m_wk == 3) begin
                        m_st = 3; m_wc = 0; m_wk = 0; m_hit = 1'b0;
                    end
                end
                default: begin
                    m_wc++;
                    if (m_wc == STB) m_st = 0;
                end
            endcase
        end
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic irq_pulse(input int n);
        @(negedge clk); #1;
        irq = 4'b0010;
        repeat (n) @(negedge clk);
        #1 irq = '0;
    endtask

    task automatic short_wake();
        @(negedge clk); #2;
        wake_async[0] = 1'b1;
        if (m_st == 2) m_hit = 1'b1;
        #0.4;
        wake_async[0] = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        #1 rst_n = 1'b1;
        tag = "R1";  wait_cyc(6);
        tag = "R7";  wr(2'd1, 8'h00); wait_cyc(13);
        wr(2'd1, 8'h02); wait_cyc(9);
        wr(2'd1, 8'h03); wait_cyc(7);
        tag = "R8";  wr(2'd1, 8'h00); wait_cyc(2);
        wr(2'd1, 8'h01); wait_cyc(8);
        wr(2'd1, 8'h00); wait_cyc(5);
        tag = "R9";  wr(2'd2, 8'hA5); wait_cyc(10);
        wr(2'd2, 8'h3C); wait_cyc(6);
        tag = "R2";  wr(2'd1, 8'h02); wait_cyc(3);
        wr(2'd0, 8'h01); wait_cyc(10);
        tag = "R10"; wr(2'd2, 8'h00); wr(2'd0, 8'h02); wait_cyc(6);
        tag = "R5";  short_wake(); wait_cyc(5);
        tag = "R3";  irq_pulse(1); wait_cyc(6);
        irq_pulse(2); wait_cyc(4);
        tag = "R4";  wr(2'd1, 8'h00); wait_cyc(3);
        wr(2'd0, 8'h02); wait_cyc(4);
        irq_pulse(3); wait_cyc(2);
        wr(2'd2, 8'hFF); wait_cyc(3);
        tag = "R5";  short_wake(); wait_cyc(3);
        tag = "R6";  wait_cyc(12);
        tag = "R11"; wait_cyc(10);
        tag = "R10"; wr(2'd0, 8'h03); wait_cyc(5);
        @(negedge clk); #1;
        wake_async[1] = 1'b1;
        if (m_st == 2) m_hit = 1'b1;
        wait_cyc(4);
        #1 wake_async[1] = 1'b0;
        tag = "R6";  wait_cyc(14);
        tag = "R10"; wr(2'd0, 8'h00); wait_cyc(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule